// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a virtual address to a physical address when no cached translation exists. It reads a two-level page table from memory. The virtual address has three fields. The top field indexes the outer table, the middle field indexes an inner table, and the low field is the byte offset inside a page. The walker first fetches the outer entry. The frame number in that entry gives the page-aligned base of an inner table. The walker then fetches the inner entry and joins its frame number with the untouched offset.

Requests are handled one at a time. The block accepts a request while `req_ready` is high. It issues at most one memory read at a time and waits for the data. It then reports either a physical address or a fault code. A bound on the number of valid outer entries is checked before any memory traffic. A clear present bit at either level ends the walk with a fault.

The frame field and the entry width are parameters. With a 24-bit frame and 64-bit entries, the block produces 36-bit physical addresses from 32-bit virtual ones.

Top module: `pgwalk_top`

## Requirements
- R1: The virtual address is split, from the most significant end, into an outer index of IDX_W bits, an inner index of IDX_W bits and a page offset of OFF_W bits.
- R2: When the outer index is greater than or equal to `tbl_len`, the walk returns fault code 1 in the cycle after acceptance and issues no memory read.
- R3: The first read goes to `tbl_base + outer_index * (ENTRY_W/8)`, taken modulo 2^PA_W.
- R4: The second read goes to `{outer_frame, OFF_W zeros} + inner_index * (ENTRY_W/8)`, taken modulo 2^PA_W. Here `outer_frame` is the frame field of the outer entry.
- R5: A table entry is present when its bit 0 is 1. A clear present bit in the outer entry ends the walk with fault code 2 after exactly one read.
- R6: A clear present bit in the inner entry ends the walk with fault code 3 after exactly two reads.
- R7: On success the result has fault code 0 and `rsp_paddr = {inner_frame, page_offset}`. The frame is entry bits [OFF_W+FRAME_W-1:OFF_W], and all other entry bits except bit 0 have no effect. On a fault `rsp_paddr` is 0.
- R8: `mem_req` is a single-cycle pulse. No further read is issued until `mem_rvalid` has returned the data of the previous one.
- R9: `rsp_valid` is high for exactly one cycle per accepted request. `req_ready` is high again in the following cycle.
- R10: After reset, `req_ready` is 1 and both `rsp_valid` and `mem_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted on this cycle if valid |
| req_vaddr | input | 2*IDX_W+OFF_W | Virtual address to translate |
| tbl_base | input | FRAME_W+OFF_W | Physical base of the outer table, sampled at acceptance |
| tbl_len | input | IDX_W+1 | Number of valid outer entries, sampled at acceptance |
| rsp_valid | output | 1 | Result pulse |
| rsp_fault_code | output | 2 | 0 ok, 1 range, 2 outer not present, 3 inner not present |
| rsp_paddr | output | FRAME_W+OFF_W | Physical address (0 on fault) |
| mem_req | output | 1 | Read request pulse |
| mem_addr | output | FRAME_W+OFF_W | Byte address of the entry to read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | ENTRY_W | Table entry returned by memory |

## Verification
The bench builds the walker with IDX_W=3, OFF_W=4, FRAME_W=10 and ENTRY_W=16. Every one of the 1024 virtual addresses can then be walked for each table configuration. The 10-bit frame is wider than the 6-bit page number, which exercises the widened physical-address path. Entries are produced arithmetically from their address, so present and absent entries appear at both levels. Filler bits are set in every entry. Three configurations are used: a full-length table, a partial bound with an outer base that wraps the physical address space, and a zero-length table.

// File: rtl/pw_pkg.sv
package pw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_READ_L1 = 3'd1,
    ST_WAIT_L1 = 3'd2,
    ST_READ_L2 = 3'd3,
    ST_WAIT_L2 = 3'd4,
    ST_DONE    = 3'd5,
    ST_FAULT   = 3'd6
  } walk_state_e;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_RANGE = 2'd1,
    FLT_OUTER = 2'd2,
    FLT_INNER = 2'd3
  } fault_e;
endpackage

// File: rtl/pw_index_unit.sv
module pw_index_unit #(
  parameter int IDX_W = 10,
  parameter int OFF_W = 12
) (
  input  logic [2*IDX_W+OFF_W-1:0] vaddr,
  input  logic [IDX_W:0]           tbl_len,
  output logic [IDX_W-1:0]         outer_idx,
  output logic [IDX_W-1:0]         inner_idx,
  output logic [OFF_W-1:0]         page_off,
  output logic                     out_of_range
);
  localparam int VA_W = 2*IDX_W + OFF_W;

  // R1: field split, outer index in the top bits
  assign outer_idx    = vaddr[VA_W-1 -: IDX_W];
  assign inner_idx    = vaddr[OFF_W +: IDX_W];
  assign page_off     = vaddr[OFF_W-1:0];
  assign out_of_range = ({1'b0, outer_idx} >= tbl_len);
endmodule

// File: rtl/pw_entry_addr.sv
module pw_entry_addr #(
  parameter int IDX_W  = 10,
  parameter int PA_W   = 32,
  parameter int ENT_SH = 2
) (
  input  logic [PA_W-1:0]  tbl_base,
  input  logic [IDX_W-1:0] idx,
  output logic [PA_W-1:0]  entry_addr
);
  logic [PA_W-1:0] idx_ext;
  assign idx_ext    = PA_W'(idx);
  assign entry_addr = tbl_base + (idx_ext << ENT_SH);
endmodule

// File: rtl/pw_entry_decode.sv
module pw_entry_decode #(
  parameter int ENTRY_W = 32,
  parameter int OFF_W   = 12,
  parameter int FRAME_W = 20
) (
  input  logic [ENTRY_W-1:0]       entry,
  output logic                     present,
  output logic [FRAME_W-1:0]       frame,
  output logic [FRAME_W+OFF_W-1:0] frame_base
);
  logic unused_entry_bits;

  assign present           = entry[0];
  assign frame             = entry[OFF_W +: FRAME_W];
  assign frame_base        = {frame, {OFF_W{1'b0}}};
  assign unused_entry_bits = ^entry;
endmodule

// File: rtl/pw_fsm.sv
module pw_fsm
  import pw_pkg::*;
#(
  parameter int IDX_W   = 10,
  parameter int OFF_W   = 12,
  parameter int FRAME_W = 20
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  input  logic                     req_out_of_range,
  input  logic [IDX_W-1:0]         req_inner_idx,
  input  logic [OFF_W-1:0]         req_page_off,
  input  logic [FRAME_W+OFF_W-1:0] l1_addr,
  input  logic [FRAME_W+OFF_W-1:0] l2_addr,
  input  logic                     mem_rvalid,
  input  logic                     ent_present,
  input  logic [FRAME_W-1:0]       ent_frame,
  output logic [IDX_W-1:0]         inner_idx_q,
  output logic                     req_ready,
  output logic                     mem_req,
  output logic [FRAME_W+OFF_W-1:0] mem_addr,
  output logic                     rsp_valid,
  output logic [1:0]               rsp_fault_code,
  output logic [FRAME_W+OFF_W-1:0] rsp_paddr
);
  localparam int PA_W = FRAME_W + OFF_W;

  walk_state_e      state;
  fault_e           code_q;
  logic [OFF_W-1:0] off_q;
  logic [PA_W-1:0]  addr_q;
  logic [PA_W-1:0]  paddr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      code_q      <= FLT_NONE;
      off_q       <= '0;
      inner_idx_q <= '0;
      addr_q      <= '0;
      paddr_q     <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            inner_idx_q <= req_inner_idx;
            off_q       <= req_page_off;
            paddr_q     <= '0;
            if (req_out_of_range) begin
              code_q <= FLT_RANGE;
              state  <= ST_FAULT;
            end else begin
              code_q <= FLT_NONE;
              addr_q <= l1_addr;
              state  <= ST_READ_L1;
            end
          end
        end
        ST_READ_L1: state <= ST_WAIT_L1;
        ST_WAIT_L1: begin
          if (mem_rvalid) begin
            if (ent_present) begin
              addr_q <= l2_addr;
              state  <= ST_READ_L2;
            end else begin
              code_q <= FLT_OUTER;
              state  <= ST_FAULT;
            end
          end
        end
        ST_READ_L2: state <= ST_WAIT_L2;
        ST_WAIT_L2: begin
          if (mem_rvalid) begin
            if (ent_present) begin
              paddr_q <= {ent_frame, off_q};
              state   <= ST_DONE;
            end else begin
              code_q <= FLT_INNER;
              state  <= ST_FAULT;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready      = (state == ST_IDLE);
  assign mem_req        = (state == ST_READ_L1) || (state == ST_READ_L2);
  assign mem_addr       = addr_q;
  assign rsp_valid      = (state == ST_DONE) || (state == ST_FAULT);
  assign rsp_fault_code = code_q;
  assign rsp_paddr      = paddr_q;

  a_r8_req_single_pulse: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);

  a_r8_no_req_while_idle: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !mem_req);

  a_r2_range_without_read: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault_code == 2'd1) |-> $past(state) == ST_IDLE);

  a_r5_outer_fault_after_read: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault_code == 2'd2) |-> $past(state) == ST_WAIT_L1);

  a_r6_inner_fault_after_read: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault_code == 2'd3) |-> $past(state) == ST_WAIT_L2);

  a_r9_rsp_one_cycle: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> (!rsp_valid && req_ready));

  a_r7_fault_clears_paddr: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault_code != 2'd0) |-> rsp_paddr == '0);
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top #(
  parameter int IDX_W   = 10,
  parameter int OFF_W   = 12,
  parameter int FRAME_W = 20,
  parameter int ENTRY_W = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [2*IDX_W+OFF_W-1:0] req_vaddr,
  input  logic [FRAME_W+OFF_W-1:0] tbl_base,
  input  logic [IDX_W:0]           tbl_len,
  output logic                     rsp_valid,
  output logic [1:0]               rsp_fault_code,
  output logic [FRAME_W+OFF_W-1:0] rsp_paddr,
  output logic                     mem_req,
  output logic [FRAME_W+OFF_W-1:0] mem_addr,
  input  logic                     mem_rvalid,
  input  logic [ENTRY_W-1:0]       mem_rdata
);
  localparam int PA_W   = FRAME_W + OFF_W;
  localparam int ENT_SH = $clog2(ENTRY_W / 8);

  logic [IDX_W-1:0] outer_idx, inner_idx, inner_idx_q;
  logic [OFF_W-1:0] page_off;
  logic             out_of_range;
  logic [PA_W-1:0]  l1_addr, l2_addr, next_base;
  logic             ent_present;
  logic [FRAME_W-1:0] ent_frame;

  pw_index_unit #(.IDX_W(IDX_W), .OFF_W(OFF_W)) u_index (
    .vaddr(req_vaddr), .tbl_len(tbl_len), .outer_idx(outer_idx),
    .inner_idx(inner_idx), .page_off(page_off), .out_of_range(out_of_range)
  );

  pw_entry_addr #(.IDX_W(IDX_W), .PA_W(PA_W), .ENT_SH(ENT_SH)) u_l1_addr (
    .tbl_base(tbl_base), .idx(outer_idx), .entry_addr(l1_addr)
  );

  pw_entry_decode #(.ENTRY_W(ENTRY_W), .OFF_W(OFF_W), .FRAME_W(FRAME_W)) u_decode (
    .entry(mem_rdata), .present(ent_present), .frame(ent_frame), .frame_base(next_base)
  );

  pw_entry_addr #(.IDX_W(IDX_W), .PA_W(PA_W), .ENT_SH(ENT_SH)) u_l2_addr (
    .tbl_base(next_base), .idx(inner_idx_q), .entry_addr(l2_addr)
  );

  pw_fsm #(.IDX_W(IDX_W), .OFF_W(OFF_W), .FRAME_W(FRAME_W)) u_fsm (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_out_of_range(out_of_range),
    .req_inner_idx(inner_idx), .req_page_off(page_off), .l1_addr(l1_addr),
    .l2_addr(l2_addr), .mem_rvalid(mem_rvalid), .ent_present(ent_present),
    .ent_frame(ent_frame), .inner_idx_q(inner_idx_q), .req_ready(req_ready),
    .mem_req(mem_req), .mem_addr(mem_addr), .rsp_valid(rsp_valid),
    .rsp_fault_code(rsp_fault_code), .rsp_paddr(rsp_paddr)
  );
endmodule

// File: tb/test_pgwalk_top.sv
module test_pgwalk_top;
  localparam int IDX_W = 3, OFF_W = 4, FRAME_W = 10, ENTRY_W = 16;
  localparam int PA_W = FRAME_W + OFF_W, VA_W = 2*IDX_W + OFF_W;

  logic clk = 0, rst = 1;
  logic req_valid = 0, mem_rvalid = 0;
  logic req_ready, rsp_valid, mem_req;
  logic [VA_W-1:0] req_vaddr = '0;
  logic [PA_W-1:0] tbl_base = '0, rsp_paddr, mem_addr;
  logic [IDX_W:0] tbl_len = '0;
  logic [1:0] rsp_fault_code;
  logic [ENTRY_W-1:0] mem_rdata = '0;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  pgwalk_top #(.IDX_W(IDX_W), .OFF_W(OFF_W), .FRAME_W(FRAME_W), .ENTRY_W(ENTRY_W)) i_pgwalk_top (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .tbl_base(tbl_base), .tbl_len(tbl_len),
    .rsp_valid(rsp_valid), .rsp_fault_code(rsp_fault_code), .rsp_paddr(rsp_paddr),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Memory image: frame and present bit derived from the entry address, filler bits set
  function automatic logic [ENTRY_W-1:0] ent(input logic [PA_W-1:0] a);
    logic [FRAME_W-1:0] fr;
    logic p;
    fr = FRAME_W'(int'(a) * 37 + 5);
    p  = ((int'(a) >> 1) % 5) != 0;
    return {2'b11, fr, a[3:1], p};
  endfunction

  task automatic walk(input logic [VA_W-1:0] va, input logic [PA_W-1:0] base,
                      input logic [IDX_W:0] len);
    int o, i, nreads, exp_reads, exp_code, lat, cnt, cyc;
    bit pending, done;
    logic [PA_W-1:0] a1, a2, exp_pa, last_addr;
    logic [ENTRY_W-1:0] e1, e2;
    o = int'(va[VA_W-1 -: IDX_W]);     // R1 outer field
    i = int'(va[OFF_W +: IDX_W]);      // R1 inner field
    a1 = base + PA_W'(o * 2);
    e1 = ent(a1);
    a2 = {e1[OFF_W +: FRAME_W], {OFF_W{1'b0}}} + PA_W'(i * 2);
    e2 = ent(a2);
    exp_pa = '0;
    if (o >= int'(len)) begin exp_code = 1; exp_reads = 0; end
    else if (!e1[0]) begin exp_code = 2; exp_reads = 1; end
    else if (!e2[0]) begin exp_code = 3; exp_reads = 2; end
    else begin exp_code = 0; exp_reads = 2; exp_pa = {e2[OFF_W +: FRAME_W], va[OFF_W-1:0]}; end
    lat = int'(va[1:0]);

    @(negedge clk);
    req_vaddr = va; tbl_base = base; tbl_len = len; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    nreads = 0; pending = 0; done = 0; cnt = 0; cyc = 0; last_addr = '0;
    while (!done) begin
      mem_rvalid = 0;
      if (rsp_valid) begin
        check(rsp_fault_code == 2'(exp_code), "R2/R5/R6/R7 fault code", rsp_fault_code, exp_code);
        check(rsp_paddr == exp_pa, "R7 paddr", rsp_paddr, exp_pa);
        check(nreads == exp_reads, "R2/R5/R6 read count", nreads, exp_reads);
        done = 1;
      end else if (mem_req) begin
        check(!pending, "R8 single outstanding read", 1, 0);
        nreads++;
        last_addr = mem_addr;
        if (nreads == 1) check(mem_addr == a1, "R3 outer entry address", mem_addr, a1);
        else check(mem_addr == a2, "R4 inner entry address", mem_addr, a2);
        pending = 1; cnt = lat;
      end else if (pending) begin
        if (cnt == 0) begin
          mem_rvalid = 1; mem_rdata = ent(last_addr); pending = 0;
        end else cnt--;
      end
      if (!done) begin
        cyc++;
        if (cyc > 100) begin
          check(0, "watchdog walk hung", cyc, 100);
          done = 1;
        end
        @(negedge clk);
      end
    end
    @(negedge clk);
    mem_rvalid = 0;
    check(!rsp_valid && req_ready, "R9 response pulse then ready", {rsp_valid, req_ready}, 1);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    check(req_ready == 1, "R10 reset ready", req_ready, 1);
    check(rsp_valid == 0, "R10 reset rsp_valid", rsp_valid, 0);
    check(mem_req == 0, "R10 reset mem_req", mem_req, 0);
    for (int v = 0; v < (1 << VA_W); v++) walk(VA_W'(v), 14'h0100, 4'd8);
    for (int v = 0; v < (1 << VA_W); v++) walk(VA_W'(v), 14'h3ffa, 4'd5);
    for (int v = 0; v < (1 << VA_W); v++) walk(VA_W'(v), 14'h02a6, 4'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule